// File: doc/BRIEF.md
# Five-Stage Pipeline Forwarding and Load-Use Stall Control

This block is the hazard control for an in-order pipeline with five stages: fetch, decode, execute, memory access and writeback. Operands are read from the register file in decode. The block compares the two source register numbers of the instruction in decode with the destination register numbers of the two older instructions ahead of it. From that comparison it sets the operand multiplexer selects that the instruction will use one cycle later, when it is in execute. It also raises a stall when a loaded value cannot yet be forwarded.

An ALU result is passed on from the execute/memory buffer to the very next instruction without a stall. A load reads its data only in the memory stage. A dependent instruction directly behind a load is therefore held in decode for one cycle, while the execute stage receives a NOP. On the following cycle the loaded value is forwarded from the memory/writeback buffer. The selects are registered inside the block, so the ALU-side multiplexers see a flop output rather than a comparator chain. The register file is assumed to write before it reads, so a producer three instructions ahead needs no forwarding path.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, both forwarding selects read 2'b00 (register file).
- R2: If the decode/execute entry has write-enable set, is not a load, and its destination equals a decode source, then that operand's select is 2'b01 (execute/memory result) in the next cycle, and no stall is raised.
- R3: If only the execute/memory entry has write-enable set with a destination equal to a decode source, that operand's select is 2'b10 (memory/writeback result) in the next cycle.
- R4: When both older entries write the same register that a source reads, the younger producer (decode/execute) wins and the select is 2'b01.
- R5: A destination whose write-enable is low causes no forwarding and no stall, even when its register number matches.
- R6: A load in decode/execute, with write-enable set and a destination equal to either decode source, raises hold_front and insert_nop in the same cycle. A load whose destination matches neither source raises neither output.
- R7: In the cycle after a stall, both selects read 2'b00, because the NOP then in execute needs no operands.
- R8: After the single bubble, the held instruction, with the load now in execute/memory, gets select 2'b10 for the matching operand, and no further stall is raised.
- R9: With no matching destination, a select reads 2'b00. The value 2'b11 never appears.
- R10: The two operand selects are decided independently, and each can name a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs_a | input | 4 | First source register of the instruction in decode |
| id_rs_b | input | 4 | Second source register of the instruction in decode |
| idex_rd | input | 4 | Destination register held in the decode/execute buffer |
| idex_we | input | 1 | Write-enable of the decode/execute entry |
| idex_load | input | 1 | Decode/execute entry is a load |
| exmem_rd | input | 4 | Destination register held in the execute/memory buffer |
| exmem_we | input | 1 | Write-enable of the execute/memory entry |
| fwd_sel_a | output | 2 | Select for ALU operand A: 00 register file, 01 execute/memory, 10 memory/writeback |
| fwd_sel_b | output | 2 | Select for ALU operand B, same encoding |
| hold_front | output | 1 | Hold the PC and the fetch/decode buffer this cycle |
| insert_nop | output | 1 | Load a NOP into the decode/execute buffer this cycle |

## Verification
The two stall outputs depend only on the current inputs. They are sampled a short settling delay after the inputs change, and before the next rising edge. The forwarding selects pass through one register, so each stimulus's select is sampled on the falling edge that follows the next rising edge, when the instruction has reached execute. The load-use case is run as a two-cycle sequence: a cycle with the stall, then a cycle with the bubble in decode/execute and the load in execute/memory. The checks cover the stall, the cleared selects and the later forward from the memory stage.

// File: rtl/hazard_pkg.sv
// Shared definitions for the pipeline hazard unit.
// Assumes: two ALU operands, a 2-bit select per operand.
package hazard_pkg;
    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_EXMEM = 2'b01,
        FWD_MEMWB = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/src_fwd_pick.sv
// Decides the forwarding source for one decode operand and flags a load-use hit.
// Assumes the decode/execute entry is younger than the execute/memory entry,
// so a match on it takes priority.
module src_fwd_pick #(
    parameter int REG_W = 4
) (
    input  logic [REG_W-1:0]    src,
    input  logic [REG_W-1:0]    idex_rd,
    input  logic                idex_we,
    input  logic                idex_load,
    input  logic [REG_W-1:0]    exmem_rd,
    input  logic                exmem_we,
    output hazard_pkg::fwd_sel_e sel_next,
    output logic                load_hit
);
    logic hit_idex;
    logic hit_exmem;

    // Match this source against each older writer.
    always_comb begin
        hit_idex  = idex_we  && (idex_rd  == src);
        hit_exmem = exmem_we && (exmem_rd == src);
    end

    // Pick the youngest ready producer; a load result is never ready this early.
    always_comb begin
        load_hit = hit_idex && idex_load;
        if (hit_idex && !idex_load)
            sel_next = hazard_pkg::FWD_EXMEM;
        else if (!hit_idex && hit_exmem)
            sel_next = hazard_pkg::FWD_MEMWB;
        else
            sel_next = hazard_pkg::FWD_RF;
    end
endmodule

// File: rtl/fwd_sel_reg.sv
// Carries the decode-time select decisions into the execute stage.
// Assumes that a stall turns the execute entry into a NOP, so the selects clear.
module fwd_sel_reg #(
    parameter int NUM_SRC = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                stall,
    input  hazard_pkg::fwd_sel_e [NUM_SRC-1:0]  sel_next,
    output hazard_pkg::fwd_sel_e [NUM_SRC-1:0]  sel_q
);
    // Register the selects; reset and stall both leave the register file chosen.
    always_ff @(posedge clk) begin
        if (!rst_n || stall) begin
            for (int i = 0; i < NUM_SRC; i++)
                sel_q[i] <= hazard_pkg::FWD_RF;
        end else begin
            sel_q <= sel_next;
        end
    end
endmodule

// File: rtl/pipe_hazard_unit.sv
// Forwarding and load-use stall control for a five-stage in-order pipeline.
// Compares decode sources with the destinations in the decode/execute and
// execute/memory buffers, registers the operand selects for execute, and
// stalls one cycle when a source depends on a load directly ahead.
// Assumes the register file writes before it reads in the same cycle.
module pipe_hazard_unit #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs_a,
    input  logic [REG_W-1:0] id_rs_b,
    input  logic [REG_W-1:0] idex_rd,
    input  logic             idex_we,
    input  logic             idex_load,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             exmem_we,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b,
    output logic             hold_front,
    output logic             insert_nop
);
    localparam int NUM_SRC = 2;

    logic [REG_W-1:0]                   src [NUM_SRC];
    hazard_pkg::fwd_sel_e [NUM_SRC-1:0] sel_next;
    hazard_pkg::fwd_sel_e [NUM_SRC-1:0] sel_q;
    logic [NUM_SRC-1:0]                 load_hit;
    logic                               stall;

    // Gather the decode sources into an indexed form.
    always_comb begin
        src[0] = id_rs_a;
        src[1] = id_rs_b;
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            src_fwd_pick #(.REG_W(REG_W)) u_pick (
                .src       (src[g]),
                .idex_rd   (idex_rd),
                .idex_we   (idex_we),
                .idex_load (idex_load),
                .exmem_rd  (exmem_rd),
                .exmem_we  (exmem_we),
                .sel_next  (sel_next[g]),
                .load_hit  (load_hit[g])
            );
        end
    endgenerate

    // Any operand waiting on a load holds the front end for one cycle.
    always_comb stall = |load_hit;

    fwd_sel_reg #(.NUM_SRC(NUM_SRC)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .sel_next (sel_next),
        .sel_q    (sel_q)
    );

    // Drive the port-level outputs.
    always_comb begin
        fwd_sel_a  = sel_q[0];
        fwd_sel_b  = sel_q[1];
        hold_front = stall;
        insert_nop = stall;
    end
endmodule

// File: rtl/hazard_checker.sv
// Temporal checks on the hazard unit's ports, bound to every instance.
// Assumes the selects appear one cycle after the decode inputs.
module hazard_checker #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] id_rs_a,
    input logic [REG_W-1:0] id_rs_b,
    input logic [REG_W-1:0] idex_rd,
    input logic             idex_we,
    input logic             idex_load,
    input logic [REG_W-1:0] exmem_rd,
    input logic             exmem_we,
    input logic [1:0]       fwd_sel_a,
    input logic [1:0]       fwd_sel_b,
    input logic             hold_front,
    input logic             insert_nop
);
    // R1: a reset cycle leaves both selects on the register file.
    a_r1_reset_sel: assert property (@(posedge clk)
        !rst_n |=> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));

    // R2: an ALU producer directly ahead forwards from execute/memory.
    a_r2_alu_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_we && !idex_load && idex_rd == id_rs_a) |=> fwd_sel_a == 2'b01);

    // R3: an older-only producer forwards from memory/writeback.
    a_r3_mem_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (!(idex_we && idex_rd == id_rs_b) && exmem_we && exmem_rd == id_rs_b && !hold_front)
        |=> fwd_sel_b == 2'b10);

    // R5: with no write-enables there is no stall and no forwarding.
    a_r5_no_we_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!idex_we && !exmem_we) |-> !hold_front);
    a_r5_no_we_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (!idex_we && !exmem_we) |=> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));

    // R6: a load feeding a decode source stalls this cycle.
    a_r6_load_use: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_we && idex_load && (idex_rd == id_rs_a || idex_rd == id_rs_b))
        |-> (hold_front && insert_nop));

    // R7: the NOP that follows a stall takes no forwarded operands.
    a_r7_bubble_sel: assert property (@(posedge clk) disable iff (!rst_n)
        insert_nop |=> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));

    // R9: the unused select code never shows up.
    a_r9_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11));
endmodule

bind pipe_hazard_unit hazard_checker #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (.*);

// File: tb/tb_pipe_hazard_unit.sv
// Bench: behavioural reference of the forwarding rules, compared each cycle.
module tb_pipe_hazard_unit;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] id_rs_a, id_rs_b, idex_rd, exmem_rd;
    logic       idex_we, idex_load, exmem_we;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic       hold_front, insert_nop;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    pipe_hazard_unit dut (
        .clk(clk), .rst_n(rst_n),
        .id_rs_a(id_rs_a), .id_rs_b(id_rs_b),
        .idex_rd(idex_rd), .idex_we(idex_we), .idex_load(idex_load),
        .exmem_rd(exmem_rd), .exmem_we(exmem_we),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .hold_front(hold_front), .insert_nop(insert_nop)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Reference: which producer an operand should take, 0 rf / 1 ex-mem / 2 mem-wb.
    function automatic int ref_pick(input int rs, input int ir, input bit iw,
                                    input int er, input bit ew);
        if (iw && ir == rs) return 1;
        if (ew && er == rs) return 2;
        return 0;
    endfunction

    // One decode cycle: drive, check the stall now, check the selects a cycle on.
    task automatic step(input int a, input int b, input int ir, input bit iw,
                        input bit il, input int er, input bit ew, input string tag);
        bit st;
        int ea, eb;
        id_rs_a = 4'(a); id_rs_b = 4'(b);
        idex_rd = 4'(ir); idex_we = iw; idex_load = il;
        exmem_rd = 4'(er); exmem_we = ew;
        #1;
        st = iw && il && (ir == a || ir == b);
        chk({tag, " hold_front"}, int'(hold_front), int'(st));
        chk({tag, " insert_nop"}, int'(insert_nop), int'(st));
        ea = st ? 0 : ref_pick(a, ir, iw, er, ew);
        eb = st ? 0 : ref_pick(b, ir, iw, er, ew);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " sel_a"}, int'(fwd_sel_a), ea);
        chk({tag, " sel_b"}, int'(fwd_sel_b), eb);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        id_rs_a = 4'd3; id_rs_b = 4'd3; idex_rd = 4'd3; idex_we = 1'b1;
        idex_load = 1'b0; exmem_rd = 4'd3; exmem_we = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset sel_a", int'(fwd_sel_a), 0);
        chk("R1 reset sel_b", int'(fwd_sel_b), 0);
        rst_n = 1'b1;

        step(1, 2, 7, 1, 0, 8, 1, "R9 no match");
        step(5, 2, 5, 1, 0, 9, 0, "R2 alu on a");
        step(1, 6, 6, 1, 0, 9, 0, "R2 alu on b");
        step(4, 2, 9, 1, 0, 4, 1, "R3 mem on a");
        step(7, 7, 7, 1, 0, 7, 1, "R4 younger wins");
        step(3, 3, 3, 0, 1, 3, 0, "R5 we low");
        step(2, 11, 2, 1, 0, 11, 1, "R10 split sources");
        step(12, 13, 5, 1, 1, 0, 0, "R6 load no match");
        step(1, 2, 2, 0, 1, 2, 0, "R5 load we low");
        // Load-use pair: stall with the load in decode/execute, then the bubble.
        step(5, 1, 5, 1, 1, 9, 0, "R6 R7 load use a");
        step(5, 1, 5, 0, 0, 5, 1, "R8 after bubble a");
        step(3, 10, 10, 1, 1, 3, 1, "R6 R7 load use b");
        step(3, 10, 10, 0, 0, 10, 1, "R8 after bubble b");

        for (int i = 0; i < 400; i++)
            step($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 3), 1'($urandom_range(0, 1)), "R10 random");

        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset again sel_a", int'(fwd_sel_a), 0);
        finish_run();
    end
endmodule